// File: doc/BRIEF.md
# Directory Home Node Controller

This block sits at the home node of a distributed shared-memory machine and keeps coherence information for the memory blocks that live in that node. For every block it tracks a coherence state and an exact set of the processors holding a copy, one bit per processor. A single processor number is enough to identify an owner, so the owner is held in that same bit vector. The block also holds the node's block memory.

Request messages arrive on a valid/ready port. Each one names a kind (read miss, write miss or data write-back), the requesting processor, the block address and, for a write-back, the data. The controller handles one request at a time. It updates the directory entry and emits a sequence of outgoing messages on a second valid/ready port. Each outgoing message carries a type code, a destination processor, the address and, for a data reply, the data.

When the block is held exclusively, the owner has to give up its data. The controller sends it a fetch, or a fetch that also invalidates, and waits for the data on a separate return port. Invalidations go point to point, only to the processors recorded as sharers, and never as a broadcast.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every block is Uncached with no sharers, memory word i holds the value i, `req_ready` is high and `msg_valid` is low.
- R2: A read miss (`req_kind` 0) to an Uncached block gets a data reply (`msg_kind` 4) to the requester carrying the memory word. The block becomes Shared with only the requester as sharer.
- R3: A write miss (`req_kind` 1) to an Uncached block gets a data reply with the memory word and sends no other message. The block becomes Exclusive, owned by the requester.
- R4: A read miss to a Shared block gets a data reply with the memory word and adds the requester to the sharers. No other sharer is disturbed.
- R5: A write miss to a Shared block sends an invalidate (`msg_kind` 1) to every sharer other than the requester, in ascending processor order, one per handshake. The data reply follows, and the block becomes Exclusive, owned by the requester.
- R6: A read miss to an Exclusive block sends a fetch (`msg_kind` 2) to the owner and waits for `fill_valid`. It writes the returned data to memory and replies with that data. The block becomes Shared, with both the old owner and the requester as sharers.
- R7: A write miss to an Exclusive block sends a fetch-and-invalidate (`msg_kind` 3) to the owner and writes the returned data to memory. It replies with that data to the requester, who becomes the sole owner.
- R8: A data write-back (`req_kind` 2) from the owner of an Exclusive block writes its data to memory and makes the block Uncached. It sends no message.
- R9: A write-back from a processor that is not the owner, or to a block that is not Exclusive, changes neither memory nor the directory.
- R10: From the acceptance of a read or write miss until its data reply is taken, `req_ready` stays low. While `msg_valid` is high and `msg_ready` low, every field of the outgoing message holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 data write-back |
| req_proc | input | PW | Requesting processor |
| req_addr | input | AW | Block address |
| req_data | input | DW | Write-back data |
| msg_valid | output | 1 | Outgoing message present |
| msg_ready | input | 1 | Network takes the message |
| msg_kind | output | 3 | 1 invalidate, 2 fetch, 3 fetch-and-invalidate, 4 data reply |
| msg_dest | output | PW | Destination processor |
| msg_addr | output | AW | Block address |
| msg_data | output | DW | Reply data (zero otherwise) |
| fill_valid | input | 1 | Owner's data returned after a fetch |
| fill_ready | output | 1 | Controller waits for owner data |
| fill_data | input | DW | Returned block data |

## Verification
After a request handshake, the first outgoing message is valid at the next clock edge. When the message queue is taken on every edge, each following invalidate, fetch or reply appears one edge after the previous one. After a fetch is taken, the controller waits for the returned data, and the reply comes one edge after that data is accepted. The bench drives and samples on the falling edge, waits for `msg_valid` before checking each field, and consumes each message on the rising edge that follows. A write-back produces no message, so the bench confirms over several falling edges that `msg_valid` stays low and `req_ready` stays high. Directory state is read only through the messages that later requests provoke.

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl #(
  parameter int NPROC = 4,
  parameter int AW    = 3,
  parameter int DW    = 8,
  localparam int PW   = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_kind,
  input  logic [PW-1:0] req_proc,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          msg_valid,
  input  logic          msg_ready,
  output logic [2:0]    msg_kind,
  output logic [PW-1:0] msg_dest,
  output logic [AW-1:0] msg_addr,
  output logic [DW-1:0] msg_data,
  input  logic          fill_valid,
  output logic          fill_ready,
  input  logic [DW-1:0] fill_data
);
  localparam int NBLK = 1 << AW;
  localparam logic [1:0] D_UNC = 2'd0, D_SHR = 2'd1, D_EXC = 2'd2;
  localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_WB = 2'd2;
  localparam logic [2:0] M_INV = 3'd1, M_FET = 3'd2, M_FINV = 3'd3, M_DATA = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_INV, S_FETCH, S_WAIT, S_REPLY} phase_t;

  logic [1:0]       dstate [NBLK];
  logic [NPROC-1:0] shv    [NBLK];
  logic [DW-1:0]    mem    [NBLK];

  phase_t           ph;
  logic [1:0]       r_kind;
  logic [PW-1:0]    r_proc;
  logic [AW-1:0]    r_addr;
  logic [PW-1:0]    r_owner;
  logic [NPROC-1:0] pend;

  function automatic logic [PW-1:0] lowest(input logic [NPROC-1:0] v);
    lowest = '0;
    for (int i = NPROC - 1; i >= 0; i--)
      if (v[i]) lowest = PW'(i);
  endfunction

  wire [NPROC-1:0] req_bit = NPROC'(1) << req_proc;
  wire [NPROC-1:0] r_bit   = NPROC'(1) << r_proc;
  wire [1:0]       cur_st  = dstate[req_addr];
  wire [NPROC-1:0] cur_sh  = shv[req_addr];
  wire             accept  = req_valid && req_ready;

  assign req_ready  = (ph == S_IDLE);
  assign fill_ready = (ph == S_WAIT);
  assign msg_valid  = (ph == S_INV) || (ph == S_FETCH) || (ph == S_REPLY);
  assign msg_addr   = r_addr;
  assign msg_kind   = (ph == S_INV)   ? M_INV :
                      (ph == S_FETCH) ? ((r_kind == K_WR) ? M_FINV : M_FET) :
                      (ph == S_REPLY) ? M_DATA : 3'd0;
  assign msg_dest   = (ph == S_INV)   ? lowest(pend) :
                      (ph == S_FETCH) ? r_owner : r_proc;
  assign msg_data   = (ph == S_REPLY) ? mem[r_addr] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph      <= S_IDLE;
      r_kind  <= K_RD;
      r_proc  <= '0;
      r_addr  <= '0;
      r_owner <= '0;
      pend    <= '0;
      for (int i = 0; i < NBLK; i++) begin
        dstate[i] <= D_UNC;
        shv[i]    <= '0;
        mem[i]    <= DW'(i);
      end
    end else begin
      case (ph)
        S_IDLE: if (accept) begin
          r_kind <= req_kind;
          r_proc <= req_proc;
          r_addr <= req_addr;
          case (req_kind)
            K_RD: begin
              if (cur_st == D_EXC) begin
                r_owner <= lowest(cur_sh);
                ph      <= S_FETCH;
              end else begin
                shv[req_addr]    <= (cur_st == D_SHR) ? (cur_sh | req_bit) : req_bit;
                dstate[req_addr] <= D_SHR;
                ph               <= S_REPLY;
              end
            end
            K_WR: begin
              if (cur_st == D_EXC) begin
                r_owner <= lowest(cur_sh);
                ph      <= S_FETCH;
              end else begin
                pend             <= (cur_st == D_SHR) ? (cur_sh & ~req_bit) : '0;
                shv[req_addr]    <= req_bit;
                dstate[req_addr] <= D_EXC;
                ph <= ((cur_st == D_SHR) && ((cur_sh & ~req_bit) != '0)) ? S_INV : S_REPLY;
              end
            end
            default: begin
              if (cur_st == D_EXC && cur_sh == req_bit) begin
                mem[req_addr]    <= req_data;
                shv[req_addr]    <= '0;
                dstate[req_addr] <= D_UNC;
              end
            end
          endcase
        end
        S_INV: if (msg_ready) begin
          pend <= pend & (pend - NPROC'(1));
          if ((pend & (pend - NPROC'(1))) == '0) ph <= S_REPLY;
        end
        S_FETCH: if (msg_ready) ph <= S_WAIT;
        S_WAIT: if (fill_valid) begin
          mem[r_addr] <= fill_data;
          if (r_kind == K_RD) begin
            shv[r_addr]    <= shv[r_addr] | r_bit;
            dstate[r_addr] <= D_SHR;
          end else begin
            shv[r_addr]    <= r_bit;
            dstate[r_addr] <= D_EXC;
          end
          ph <= S_REPLY;
        end
        S_REPLY: if (msg_ready) ph <= S_IDLE;
        default: ph <= S_IDLE;
      endcase
    end
  end

  generate
    for (genvar g = 0; g < NBLK; g++) begin : g_dir_chk
      p_owner_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dstate[g] == D_EXC |-> $countones(shv[g]) == 1);
      p_uncached_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dstate[g] == D_UNC |-> shv[g] == '0);
      p_shared_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dstate[g] == D_SHR |-> shv[g] != '0);
    end
  endgenerate

  p_msg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_kind) && $stable(msg_dest)
                                && $stable(msg_addr) && $stable(msg_data));
  p_busy_no_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> !req_ready);
  p_inv_ascending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_ready && msg_kind == M_INV |=>
      msg_kind != M_INV || msg_dest > $past(msg_dest));
  p_no_self_inv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_kind == M_INV |-> msg_dest != r_proc);
endmodule

// File: tb/dir_home_ctrl_tb.sv
module dir_home_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NPROC = 4, AW = 3, DW = 8, PW = 2;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, msg_ready = 1, fill_valid = 0;
  logic [1:0] req_kind = 0;
  logic [PW-1:0] req_proc = 0;
  logic [AW-1:0] req_addr = 0;
  logic [DW-1:0] req_data = 0, fill_data = 0;
  logic req_ready, msg_valid, fill_ready;
  logic [2:0] msg_kind;
  logic [PW-1:0] msg_dest;
  logic [AW-1:0] msg_addr;
  logic [DW-1:0] msg_data;
  int n_chk = 0, n_fail = 0, cyc = 0;

  dir_home_ctrl #(.NPROC(NPROC), .AW(AW), .DW(DW)) u_dut (
    .clk, .rst_n, .req_valid, .req_ready, .req_kind, .req_proc, .req_addr, .req_data,
    .msg_valid, .msg_ready, .msg_kind, .msg_dest, .msg_addr, .msg_data,
    .fill_valid, .fill_ready, .fill_data);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send_req(input int k, input int p, input int a, input int d);
    @(negedge clk);
    req_valid = 1; req_kind = 2'(k); req_proc = PW'(p); req_addr = AW'(a); req_data = DW'(d);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic expect_msg(input int t, input int d, input int a, input int dat,
                            input string tag, input int stall);
    int n = 0;
    while (!msg_valid && n < 50) begin @(negedge clk); n++; end
    chk(msg_valid, {tag, " valid"}, msg_valid, 1);
    if (stall > 0) begin
      logic [2:0] k0; logic [PW-1:0] d0; logic [DW-1:0] v0;
      msg_ready = 0; k0 = msg_kind; d0 = msg_dest; v0 = msg_data;
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        chk(msg_valid && msg_kind == k0 && msg_dest == d0 && msg_data == v0,
            "R10 held message", msg_kind, k0);
        chk(!req_ready, "R10 req_ready low", req_ready, 0);
      end
      msg_ready = 1;
    end
    chk(msg_kind == 3'(t), {tag, " kind"}, msg_kind, t);
    chk(msg_dest == PW'(d), {tag, " dest"}, msg_dest, d);
    chk(msg_addr == AW'(a), {tag, " addr"}, msg_addr, a);
    chk(msg_data == DW'(dat), {tag, " data"}, msg_data, dat);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic give_fill(input int d);
    fill_valid = 1; fill_data = DW'(d);
    while (!fill_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic quiet(input string tag);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!msg_valid && req_ready, tag, msg_valid, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1, "R1 req_ready", req_ready, 1);
    chk(msg_valid == 0, "R1 msg_valid", msg_valid, 0);

    // R1 R2: every block replies its reset value and becomes Shared
    for (int a = 0; a < 8; a++) begin
      send_req(0, a % 4, a, 0);
      expect_msg(4, a % 4, a, a, "R1 R2 uncached read", 0);
    end
    // R4: other processors join block 0
    for (int p = 1; p < 4; p++) begin
      send_req(0, p, 0, 0);
      expect_msg(4, p, 0, 0, "R4 shared read", 0);
    end
    // R5: write by 2 invalidates 0,1,3 in order
    send_req(1, 2, 0, 0);
    expect_msg(1, 0, 0, 0, "R5 inv", 0);
    expect_msg(1, 1, 0, 0, "R5 inv", 0);
    expect_msg(1, 3, 0, 0, "R5 inv", 0);
    expect_msg(4, 2, 0, 0, "R5 reply", 2);
    // R6: read by 1 fetches from owner 2
    send_req(0, 1, 0, 0);
    expect_msg(2, 2, 0, 0, "R6 fetch", 0);
    give_fill(8'hA5);
    expect_msg(4, 1, 0, 8'hA5, "R6 reply", 0);
    // R6 sharers {1,2}: write by 3 invalidates both
    send_req(1, 3, 0, 0);
    expect_msg(1, 1, 0, 0, "R6 R5 inv", 0);
    expect_msg(1, 2, 0, 0, "R6 R5 inv", 0);
    expect_msg(4, 3, 0, 8'hA5, "R5 reply", 0);
    // R7: write by 0 takes ownership from 3
    send_req(1, 0, 0, 0);
    expect_msg(3, 3, 0, 0, "R7 fetch-inv", 1);
    give_fill(8'h3C);
    expect_msg(4, 0, 0, 8'h3C, "R7 reply", 0);
    // R9: write-back from non-owner 2 is ignored
    send_req(2, 2, 0, 8'hEE);
    quiet("R9 no message");
    send_req(0, 1, 0, 0);
    expect_msg(2, 0, 0, 0, "R9 R7 owner kept", 0);
    give_fill(8'h77);
    expect_msg(4, 1, 0, 8'h77, "R9 R6 reply", 0);
    // R9: write-back to a Shared block is ignored
    send_req(2, 0, 0, 8'h11);
    quiet("R9 no message shared");
    send_req(1, 2, 0, 0);
    expect_msg(1, 0, 0, 0, "R9 sharers kept", 0);
    expect_msg(1, 1, 0, 0, "R9 sharers kept", 0);
    expect_msg(4, 2, 0, 8'h77, "R9 memory kept", 0);
    // R8: owner 2 writes back
    send_req(2, 2, 0, 8'h5E);
    quiet("R8 no message");
    // R3: uncached write replies directly
    send_req(1, 3, 0, 0);
    expect_msg(4, 3, 0, 8'h5E, "R8 R3 uncached write", 0);
    send_req(0, 0, 0, 0);
    expect_msg(2, 3, 0, 0, "R3 owner is 3", 0);
    give_fill(8'h42);
    expect_msg(4, 0, 0, 8'h42, "R6 reply", 0);
    // R5: write by sole sharer has no invalidates
    send_req(1, 5 % 4, 5, 0);
    expect_msg(4, 1, 5, 5, "R5 sole sharer", 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule